// File: doc/BRIEF.md
# Programmable Six-Mode Counter Channel

This block is a single channel of an interval timer. It holds a presettable down counter that counts either in plain binary or as four BCD decades, and it turns that count into an output waveform. The channel clock and the gate input come from outside and are resampled on the system clock. The count moves on the falling edge of the channel clock. The gate level is taken on the rising edge, and a rising gate edge is remembered as a trigger until the next falling edge of the channel clock.

A host interface block, not part of this design, decodes the bus and passes in three things: a control-word strobe carrying a mode number and a BCD flag, a count-write strobe carrying the full count value, and a strobe that marks a half-written two-byte count. The channel supports six waveform modes: terminal-count interrupt, retriggerable one-shot, rate generator, square wave, software-triggered strobe and hardware-triggered strobe. It drives the output level and the live count. Each time the stored count is copied into the counter, it also raises a one-cycle "count loaded" pulse, which the interface block uses to clear its pending-count flag.

Top module: `tmr_channel`

## Requirements
- R1: After reset, out_o is 1, count_o is 0 and loaded_o is 0.
- R2: A control word sets out_o to 0 when cw_mode_i is 0 and to 1 for every other mode. Mode values 6 and 7 behave as modes 2 and 3.
- R3: Each copy of the stored count into the counter raises loaded_o for exactly one system cycle. That copy happens only on a falling edge of chan_clk_i. count_o changes only on those edges.
- R4: With cw_bcd_i=1 the counter counts down in four BCD decades and wraps from 0000 to 9999. With cw_bcd_i=0 it counts down in binary and wraps from 0000 to FFFF. A written value of 0 is therefore the largest count.
- R5: In mode 0, a count N is loaded on the first channel-clock pulse after it is written, with no decrement on that pulse. out_o rises at pulse N+1 and stays high. The count holds while the gate is low. Writing a count sets out_o back to 0.
- R6: In mode 0, a cnt_half_i strobe sets out_o to 0 and stops counting until the next count write. That count is then loaded on the next pulse.
- R7: In mode 1, a gate rising edge with a count present loads the count and drives out_o low on the next pulse. out_o stays low for N pulses. A new trigger during the pulse restarts the N-pulse window.
- R8: In mode 2, out_o is high except for one pulse in every N. It is low after pulse k exactly when k is a multiple of N, with pulse 1 being the load.
- R9: In modes 2 and 3, a low gate forces out_o high within a few system cycles. A gate rising edge reloads the count on the next pulse and starts a new period.
- R10: In mode 3, with period N, out_o is high for (N+1)/2 pulses and then low for the rest. The counter steps by 2 and starts from N for even N and from N-1 for odd N.
- R11: In modes 2 and 3, a count written while counting takes effect at the end of the current period or half-cycle, not before.
- R12: In mode 4, out_o goes low for exactly one pulse, at pulse N+1 after the count write, and does not strobe again until a new count is written.
- R13: In mode 5, nothing happens until a gate rising edge. out_o then goes low for exactly one pulse, at pulse N+1 after the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_clk_i | input | 1 | Channel count clock, resampled on clk |
| gate_i | input | 1 | Gate input, resampled on clk |
| cw_wr_i | input | 1 | Control-word strobe, one clk cycle |
| cw_mode_i | input | 3 | Mode number carried with the control word |
| cw_bcd_i | input | 1 | 1 = BCD counting, 0 = binary |
| cnt_wr_i | input | 1 | Full count written, one clk cycle |
| cnt_val_i | input | W | Count value carried by cnt_wr_i |
| cnt_half_i | input | 1 | First byte of a two-byte count written |
| out_o | output | 1 | Channel output waveform |
| count_o | output | W | Live counter value |
| loaded_o | output | 1 | One-cycle pulse when the count is copied into the counter |

## Verification
The sensitive overlap is between a host count write and the reload point that ends a rate-generator period. The same point also collides with a gate trigger that asks for an early reload. The bench writes a new count part-way through a period. It then checks pulse by pulse that the old period still ends on time and that the next period has the new length, counting loaded_o pulses over the window. It also drops and raises the gate while out_o is low, and judges both the forced-high level and where the restarted period falls.

// File: rtl/tmr_channel_pkg.sv
package tmr_channel_pkg;

   typedef enum logic [2:0] {
      MD_TC_IRQ    = 3'd0,
      MD_ONESHOT   = 3'd1,
      MD_RATE      = 3'd2,
      MD_SQUARE    = 3'd3,
      MD_SW_STROBE = 3'd4,
      MD_HW_STROBE = 3'd5
   } tmr_mode_e;

   // codes 6 and 7 alias the periodic modes 2 and 3
   function automatic tmr_mode_e fold_mode(input logic [2:0] m);
      if (m[1])
         return tmr_mode_e'({1'b0, m[1:0]});
      else
         return tmr_mode_e'(m);
   endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic q_dly_o
);
   localparam int LAST = STAGES;

   logic [LAST:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[LAST-1:0], d_i};
   end

   assign q_o     = sh_q[LAST-1];
   assign q_dly_o = sh_q[LAST];
endmodule

// File: rtl/tmr_dec.sv
module tmr_dec #(
   parameter int W = 16
) (
   input  logic [W-1:0] val_i,
   input  logic         bcd_i,
   input  logic         by_two_i,
   output logic [W-1:0] dec_o
);
   localparam int DIG = W / 4;

   logic [1:0]   bw   [DIG];
   logic [W-1:0] bcd_res;
   logic [W-1:0] bin_res;

   assign bw[0]   = by_two_i ? 2'd2 : 2'd1;
   assign bin_res = val_i - {{(W-2){1'b0}}, bw[0]};

   for (genvar i = 0; i < DIG; i++) begin : g_digit
      logic [3:0] d;
      logic       under;
      assign d     = val_i[4*i +: 4];
      assign under = d < {2'b00, bw[i]};
      assign bcd_res[4*i +: 4] = under ? (d + 4'd10 - {2'b00, bw[i]})
                                       : (d - {2'b00, bw[i]});
      if (i < DIG - 1) begin : g_chain
         assign bw[i+1] = under ? 2'd1 : 2'd0;
      end
   end

   assign dec_o = bcd_i ? bcd_res : bin_res;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_channel_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         chan_clk_i,
   input  logic         gate_i,
   input  logic         cw_wr_i,
   input  logic [2:0]   cw_mode_i,
   input  logic         cw_bcd_i,
   input  logic         cnt_wr_i,
   input  logic [W-1:0] cnt_val_i,
   input  logic         cnt_half_i,
   output logic         out_o,
   output logic [W-1:0] count_o,
   output logic         loaded_o
);
   localparam logic [W-1:0] ONE = W'(1);
   localparam logic [W-1:0] TWO = W'(2);

   if (W % 4 != 0 || W < 8) begin : g_bad_width
      $error("tmr_channel: W must be a multiple of 4 and at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_channel: SYNC_STAGES must be at least 2");
   end

   logic ck_q, ck_d, gt_q, gt_d;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
      .clk(clk), .rst_n(rst_n), .d_i(chan_clk_i), .q_o(ck_q), .q_dly_o(ck_d));
   tmr_sync #(.STAGES(SYNC_STAGES)) u_gt_sync (
      .clk(clk), .rst_n(rst_n), .d_i(gate_i), .q_o(gt_q), .q_dly_o(gt_d));

   logic tick, ck_rise, g_rise;
   assign tick    = ck_d & ~ck_q;
   assign ck_rise = ~ck_d & ck_q;
   assign g_rise  = gt_q & ~gt_d;

   tmr_mode_e    mode_q;
   logic [W-1:0] ce_q, cr_q, dec_v, sq_load;
   logic         bcd_q, out_q, have_cr_q, pend_q, run_q, halt_q;
   logic         trig_q, fired_q, odd_q, gate_lv_q, ld_q;
   logic         can_trig, sq_expire;

   tmr_dec #(.W(W)) u_dec (
      .val_i(ce_q), .bcd_i(bcd_q), .by_two_i(mode_q == MD_SQUARE), .dec_o(dec_v));

   assign can_trig  = trig_q & have_cr_q;
   assign sq_load   = {cr_q[W-1:1], 1'b0};
   assign sq_expire = (out_q && odd_q) ? (ce_q == '0) : (ce_q == TWO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MD_TC_IRQ;
         ce_q      <= '0;
         cr_q      <= '0;
         bcd_q     <= 1'b0;
         out_q     <= 1'b1;
         have_cr_q <= 1'b0;
         pend_q    <= 1'b0;
         run_q     <= 1'b0;
         halt_q    <= 1'b0;
         trig_q    <= 1'b0;
         fired_q   <= 1'b0;
         odd_q     <= 1'b0;
         gate_lv_q <= 1'b0;
         ld_q      <= 1'b0;
      end else begin
         ld_q <= 1'b0;
         if (ck_rise) gate_lv_q <= gt_q;
         if (cw_wr_i) begin
            mode_q    <= fold_mode(cw_mode_i);
            bcd_q     <= cw_bcd_i;
            out_q     <= (fold_mode(cw_mode_i) != MD_TC_IRQ);
            have_cr_q <= 1'b0;
            pend_q    <= 1'b0;
            run_q     <= 1'b0;
            halt_q    <= 1'b0;
            trig_q    <= 1'b0;
            fired_q   <= 1'b0;
         end else begin
            if (tick) begin
               trig_q <= 1'b0;
               case (mode_q)
                  MD_TC_IRQ: begin
                     if (pend_q) begin
                        ce_q <= cr_q; pend_q <= 1'b0; run_q <= 1'b1; ld_q <= 1'b1;
                     end else if (run_q && gate_lv_q && !halt_q) begin
                        ce_q <= dec_v;
                        if (ce_q == ONE) out_q <= 1'b1;
                     end
                  end
                  MD_ONESHOT: begin
                     if (can_trig) begin
                        ce_q <= cr_q; pend_q <= 1'b0; run_q <= 1'b1;
                        out_q <= 1'b0; ld_q <= 1'b1;
                     end else if (run_q) begin
                        ce_q <= dec_v;
                        if (ce_q == ONE) out_q <= 1'b1;
                     end
                  end
                  MD_RATE: begin
                     if (can_trig || (!run_q && pend_q)) begin
                        ce_q <= cr_q; pend_q <= 1'b0; run_q <= 1'b1;
                        out_q <= 1'b1; ld_q <= 1'b1;
                     end else if (run_q && gate_lv_q) begin
                        if (ce_q == ONE) begin
                           ce_q <= cr_q; pend_q <= 1'b0; out_q <= 1'b1; ld_q <= 1'b1;
                        end else begin
                           ce_q <= dec_v;
                           if (ce_q == TWO) out_q <= 1'b0;
                        end
                     end
                  end
                  MD_SQUARE: begin
                     if (can_trig || (!run_q && pend_q)) begin
                        ce_q <= sq_load; odd_q <= cr_q[0]; pend_q <= 1'b0;
                        run_q <= 1'b1; out_q <= 1'b1; ld_q <= 1'b1;
                     end else if (run_q && gate_lv_q) begin
                        if (sq_expire) begin
                           ce_q <= sq_load; odd_q <= cr_q[0]; pend_q <= 1'b0;
                           out_q <= ~out_q; ld_q <= 1'b1;
                        end else begin
                           ce_q <= dec_v;
                        end
                     end
                  end
                  MD_SW_STROBE: begin
                     if (!out_q) out_q <= 1'b1;
                     if (pend_q) begin
                        ce_q <= cr_q; pend_q <= 1'b0; run_q <= 1'b1;
                        fired_q <= 1'b0; ld_q <= 1'b1;
                     end else if (run_q && gate_lv_q) begin
                        ce_q <= dec_v;
                        if (ce_q == ONE && !fired_q) begin
                           out_q <= 1'b0; fired_q <= 1'b1;
                        end
                     end
                  end
                  MD_HW_STROBE: begin
                     if (!out_q) out_q <= 1'b1;
                     if (can_trig) begin
                        ce_q <= cr_q; pend_q <= 1'b0; run_q <= 1'b1;
                        fired_q <= 1'b0; ld_q <= 1'b1;
                     end else if (run_q) begin
                        ce_q <= dec_v;
                        if (ce_q == ONE && !fired_q) begin
                           out_q <= 1'b0; fired_q <= 1'b1;
                        end
                     end
                  end
                  default: ;
               endcase
            end
            if (g_rise) trig_q <= 1'b1;
            if (cnt_wr_i) begin
               cr_q      <= cnt_val_i;
               have_cr_q <= 1'b1;
               pend_q    <= 1'b1;
               halt_q    <= 1'b0;
               if (mode_q == MD_TC_IRQ) out_q <= 1'b0;
            end
            if (cnt_half_i && mode_q == MD_TC_IRQ) begin
               halt_q <= 1'b1;
               out_q  <= 1'b0;
            end
            if (!gt_q && (mode_q == MD_RATE || mode_q == MD_SQUARE)) out_q <= 1'b1;
         end
      end
   end

   assign out_o    = out_q;
   assign count_o  = ce_q;
   assign loaded_o = ld_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cw_wr_i,
   input logic [2:0]   cw_mode_i,
   input logic         out_o,
   input logic [W-1:0] count_o,
   input logic         loaded_o,
   input logic         tick,
   input logic [2:0]   mode,
   input logic         gate_s
);
   // R2: mode 0 control word drives the output low
   a_r2_mode0_cw_low: assert property (@(posedge clk) disable iff (!rst_n)
      cw_wr_i && cw_mode_i == 3'd0 |=> !out_o);

   // R3: the loaded pulse lasts one cycle
   a_r3_load_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_o |=> !loaded_o);

   // R3: a load follows a channel-clock falling edge
   a_r3_load_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_o |-> $past(tick));

   // R3: the count moves only after a falling edge
   a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count_o));

   // R7: a one-shot load coincides with the output going low
   a_r7_trigger_load_low: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'd1 && loaded_o |-> !out_o);

   // R9: low gate forces the periodic modes high
   a_r9_gate_low_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2 || mode == 3'd3) && !gate_s && !cw_wr_i |=> out_o);

   // R12 and R13: strobe lasts a single pulse
   a_r12_strobe_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 || mode == 3'd5) && !out_o && tick && !cw_wr_i |=> out_o);
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cw_wr_i(cw_wr_i), .cw_mode_i(cw_mode_i),
   .out_o(out_o), .count_o(count_o), .loaded_o(loaded_o), .tick(tick),
   .mode(mode_q), .gate_s(gt_q));

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_clk = 1'b0;
   logic        gate = 1'b0;
   logic        cw_wr = 1'b0;
   logic [2:0]  cw_mode = 3'd0;
   logic        cw_bcd = 1'b0;
   logic        cnt_wr = 1'b0;
   logic [15:0] cnt_val = 16'd0;
   logic        cnt_half = 1'b0;
   logic        out;
   logic [15:0] count;
   logic        loaded;

   int n_chk = 0;
   int n_fail = 0;
   int ld_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tmr_channel uut (
      .clk(clk), .rst_n(rst_n), .chan_clk_i(chan_clk), .gate_i(gate),
      .cw_wr_i(cw_wr), .cw_mode_i(cw_mode), .cw_bcd_i(cw_bcd),
      .cnt_wr_i(cnt_wr), .cnt_val_i(cnt_val), .cnt_half_i(cnt_half),
      .out_o(out), .count_o(count), .loaded_o(loaded));

   always @(posedge clk) if (loaded) ld_seen <= ld_seen + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      @(negedge clk) chan_clk = 1'b1;
      wait_n(6);
      chan_clk = 1'b0;
      wait_n(6);
   endtask

   task automatic cw(input logic [2:0] m, input logic b);
      @(negedge clk) begin cw_mode = m; cw_bcd = b; cw_wr = 1'b1; end
      @(negedge clk) cw_wr = 1'b0;
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk) begin cnt_val = v; cnt_wr = 1'b1; end
      @(negedge clk) cnt_wr = 1'b0;
   endtask

   task automatic set_gate(input logic g);
      @(negedge clk) gate = g;
      wait_n(5);
   endtask

   function automatic logic [15:0] bcd_dec(input logic [15:0] v);
      logic [15:0] r = v;
      for (int i = 0; i < 4; i++) begin
         if (r[4*i +: 4] != 4'd0) begin
            r[4*i +: 4] = r[4*i +: 4] - 4'd1;
            return r;
         end
         r[4*i +: 4] = 4'd9;
      end
      return r;
   endfunction

   function automatic logic exp_rate(input int k, input int n);
      return (k % n) != 0;
   endfunction

   function automatic logic exp_square(input int k, input int n);
      return ((k - 1) % n) < ((n + 1) / 2);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int unsigned seed_dummy;
      int n, n2, l0;
      logic [15:0] v;
      seed_dummy = $urandom(32'h1A2B);
      wait_n(4);
      chk("R1 out after reset", {31'd0, out}, 32'd1);
      chk("R1 count after reset", {16'd0, count}, 32'd0);
      chk("R1 loaded after reset", {31'd0, loaded}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      wait_n(3);

      // R5: mode 0 timing with random counts
      set_gate(1'b1);
      for (int rep = 0; rep < 3; rep++) begin
         n = 2 + int'($urandom % 12);
         cw(3'd0, 1'b0);
         chk("R2 mode 0 control word drives low", {31'd0, out}, 32'd0);
         wr(16'(n));
         for (int k = 1; k <= n + 1; k++) begin
            pulse();
            chk("R5 mode 0 output", {31'd0, out}, (k == n + 1) ? 32'd1 : 32'd0);
            chk("R5 mode 0 count", {16'd0, count}, (k == 1) ? 32'(n) : 32'(n - (k - 1)));
         end
      end
      wr(16'd7);
      chk("R5 count write drives low", {31'd0, out}, 32'd0);

      // R5: gate low holds the count
      cw(3'd0, 1'b0);
      wr(16'd10);
      repeat (3) pulse();
      chk("R5 count before gate low", {16'd0, count}, 32'd8);
      set_gate(1'b0);
      repeat (3) pulse();
      chk("R5 gate low holds count", {16'd0, count}, 32'd8);
      set_gate(1'b1);

      // R6: half write stops counting
      cw(3'd0, 1'b0);
      wr(16'd5);
      pulse(); pulse();
      chk("R6 count before half write", {16'd0, count}, 32'd4);
      @(negedge clk) cnt_half = 1'b1;
      @(negedge clk) cnt_half = 1'b0;
      repeat (3) pulse();
      chk("R6 halted count", {16'd0, count}, 32'd4);
      chk("R6 halted output low", {31'd0, out}, 32'd0);
      wr(16'd3);
      pulse();
      chk("R6 new count loaded", {16'd0, count}, 32'd3);
      pulse(); pulse();
      chk("R6 output still low", {31'd0, out}, 32'd0);
      pulse();
      chk("R6 output high at terminal", {31'd0, out}, 32'd1);

      // R4: binary and BCD wrap, random BCD decrements
      cw(3'd0, 1'b0);
      wr(16'd0);
      pulse(); pulse();
      chk("R4 binary wrap", {16'd0, count}, 32'h0000FFFF);
      cw(3'd0, 1'b1);
      wr(16'd0);
      pulse(); pulse();
      chk("R4 bcd wrap", {16'd0, count}, 32'h00009999);
      for (int rep = 0; rep < 4; rep++) begin
         for (int d = 0; d < 4; d++) v[4*d +: 4] = 4'($urandom % 10);
         if (rep == 0) v = 16'h0100;
         cw(3'd0, 1'b1);
         wr(v);
         pulse(); pulse();
         chk("R4 bcd decrement", {16'd0, count}, {16'd0, bcd_dec(v)});
      end

      // R7: one-shot
      set_gate(1'b0);
      cw(3'd1, 1'b0);
      chk("R2 mode 1 control word high", {31'd0, out}, 32'd1);
      n = 3 + int'($urandom % 6);
      wr(16'(n));
      pulse(); pulse();
      chk("R7 no trigger keeps high", {31'd0, out}, 32'd1);
      set_gate(1'b1);
      for (int k = 1; k <= n + 1; k++) begin
         pulse();
         chk("R7 one-shot output", {31'd0, out}, (k == n + 1) ? 32'd1 : 32'd0);
      end
      set_gate(1'b0);
      set_gate(1'b1);
      pulse(); pulse();
      set_gate(1'b0);
      set_gate(1'b1);
      for (int k = 3; k <= n + 3; k++) begin
         pulse();
         chk("R7 retrigger extends", {31'd0, out}, (k == n + 3) ? 32'd1 : 32'd0);
      end

      // R8: rate generator, code 6 aliases mode 2
      for (int rep = 0; rep < 2; rep++) begin
         n = 2 + int'($urandom % 9);
         cw(rep == 0 ? 3'd6 : 3'd2, 1'b0);
         chk("R2 mode 2 control word high", {31'd0, out}, 32'd1);
         wr(16'(n));
         l0 = ld_seen;
         for (int k = 1; k <= 3 * n; k++) begin
            pulse();
            chk("R8 rate output", {31'd0, out}, {31'd0, exp_rate(k, n)});
         end
         chk("R3 one load per period", 32'(ld_seen - l0), 32'd3);
      end

      // R9: gate low forces high, rising gate restarts
      n = 4;
      cw(3'd2, 1'b0);
      wr(16'(n));
      repeat (n) pulse();
      chk("R9 output low at period end", {31'd0, out}, 32'd0);
      @(negedge clk) gate = 1'b0;
      wait_n(5);
      chk("R9 gate low forces high", {31'd0, out}, 32'd1);
      set_gate(1'b1);
      for (int k = 1; k <= n; k++) begin
         pulse();
         chk("R9 restarted period", {31'd0, out}, (k == n) ? 32'd0 : 32'd1);
      end

      // R11: new count used at end of current period
      cw(3'd2, 1'b0);
      wr(16'd4);
      l0 = ld_seen;
      for (int k = 1; k <= 10; k++) begin
         pulse();
         if (k == 2) wr(16'd6);
         chk("R11 deferred count", {31'd0, out}, (k == 4 || k == 10) ? 32'd0 : 32'd1);
      end
      chk("R11 loads in window", 32'(ld_seen - l0), 32'd2);

      // R10: square wave, random odd and even
      for (int rep = 0; rep < 4; rep++) begin
         n = 2 + int'($urandom % 12);
         if (rep == 0) n = 6;
         if (rep == 1) n = 5;
         cw(rep == 2 ? 3'd7 : 3'd3, 1'b0);
         wr(16'(n));
         for (int k = 1; k <= 2 * n + 3; k++) begin
            pulse();
            chk("R10 square output", {31'd0, out}, {31'd0, exp_square(k, n)});
            if (rep == 0 && k == 2)
               chk("R10 steps by two", {16'd0, count}, 32'd4);
            if (rep == 1 && k == 1)
               chk("R10 odd loads N-1", {16'd0, count}, 32'd4);
         end
      end

      // R12: software strobe
      n = 2 + int'($urandom % 8);
      cw(3'd4, 1'b0);
      wr(16'(n));
      for (int k = 1; k <= n + 4; k++) begin
         pulse();
         chk("R12 strobe output", {31'd0, out}, (k == n + 1) ? 32'd0 : 32'd1);
      end

      // R13: hardware strobe
      set_gate(1'b0);
      n2 = 2 + int'($urandom % 8);
      cw(3'd5, 1'b0);
      wr(16'(n2));
      repeat (3) pulse();
      chk("R13 idle without trigger", {31'd0, out}, 32'd1);
      set_gate(1'b1);
      for (int k = 1; k <= n2 + 3; k++) begin
         pulse();
         chk("R13 triggered strobe", {31'd0, out}, (k == n2 + 1) ? 32'd0 : 32'd1);
      end

      done = 1'b1;
      summary();
   end
endmodule